// File: doc/BRIEF.md
# Dual Halfword Clamp with Sticky Saturation Flag

This block clamps a 32-bit word holding two signed 16-bit lanes into a range chosen per operation. Each lane is handled on its own, so one lane may be limited while the other passes through untouched. The two clamped lanes are packed back into a 32-bit result, which is registered one clock after the request strobe.

A one-bit mode picks the kind of range. In signed mode the range is symmetric in two's complement. In unsigned mode the range runs from zero up to a power of two minus one, so negative lanes become zero. A 4-bit select field sets the range width.

Whenever any lane had to be limited, a sticky saturation flag is raised. The clamp operation itself never lowers this flag. It falls only through a dedicated clear input, and that clear wins over a set in the same cycle. Decoding the operation and any shift applied before the clamp are handled outside this block.

Top module: `hw_pair_clamp`

## Requirements
- R1: While `rst` is high at a rising edge, `out_word` becomes 0, `out_vld` becomes 0 and `sat_flag` becomes 0.
- R2: `out_vld` is high exactly in the cycle after a cycle with `in_vld` high. `out_word` is updated only at edges where `in_vld` is high, and otherwise keeps its value.
- R3: With `in_mode`=0 (signed), select value s gives a range from -2^s to 2^s-1, for s in 0..15. A lane above the maximum becomes the maximum, and a lane below the minimum becomes the minimum.
- R4: With `in_mode`=1 (unsigned), select value s gives a range from 0 to 2^s-1, for s in 0..15. A negative lane becomes 0, and a lane above the maximum becomes the maximum.
- R5: The clamped lane taken from `in_word[15:0]` appears in `out_word[15:0]`. The clamped lane taken from `in_word[31:16]` appears in `out_word[31:16]`. Each lane is a 16-bit two's complement value.
- R6: Lanes are independent. Limiting one lane does not change the value of the other lane.
- R7: An accepted request in which at least one lane is limited sets `sat_flag` at the same edge that registers the result. No request ever clears `sat_flag`.
- R8: `flag_clr` high at an edge makes `sat_flag` 0 after that edge, even when a limiting request is accepted at the same edge. The result is still written at that edge.
- R9: A lane that is already inside the range passes unchanged and does not set `sat_flag`. In signed mode with s=15, every input word passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Request strobe |
| in_mode | input | 1 | 0 = signed range, 1 = unsigned range |
| in_sel | input | 4 | Range select s |
| in_word | input | 32 | Two packed signed lanes |
| flag_clr | input | 1 | Clears the sticky flag, wins over a set |
| out_vld | output | 1 | Result strobe, one cycle after the request |
| out_word | output | 32 | Packed clamped lanes |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Some properties are checked on every cycle: the result strobe follows the request strobe, the result word holds while no request arrives, the flag stays set until it is cleared, the flag rises only after an accepted request, and the clear takes effect at once. They also check that unsigned results never carry a sign bit and that the full-width signed range passes words unchanged. The exact clamped values need the bench. So do the exact edges of each range, the independence of the lanes, and a clear arriving in the same cycle as a limiting request. The bench covers these with directed cases and a sweep of every select value in both modes.

// File: rtl/hwsat_pkg.sv
package hwsat_pkg;

    localparam int HW_LANE_W = 16;
    localparam int HW_SEL_W  = $clog2(HW_LANE_W);
    localparam int HW_BND_W  = HW_LANE_W + 1;

    typedef enum logic {
        SAT_SIGNED   = 1'b0,
        SAT_UNSIGNED = 1'b1
    } sat_mode_e;

    typedef struct packed {
        logic signed [HW_BND_W-1:0] lo;
        logic signed [HW_BND_W-1:0] hi;
    } sat_bounds_t;

    typedef struct packed {
        logic                 clip;
        logic [HW_LANE_W-1:0] val;
    } lane_res_t;

    function automatic logic signed [HW_BND_W-1:0] pow2(input logic [HW_SEL_W-1:0] s);
        return $signed(HW_BND_W'(1) << s);
    endfunction

endpackage

// File: rtl/hwsat_bounds.sv
module hwsat_bounds
    import hwsat_pkg::*;
(
    input  sat_mode_e             mode,
    input  logic [HW_SEL_W-1:0]   sel,
    output sat_bounds_t           bnd
);
    logic signed [HW_BND_W-1:0] step;

    always_comb begin
        step   = pow2(sel);
        bnd.hi = step - HW_BND_W'(1);
        bnd.lo = (mode == SAT_SIGNED) ? -step : '0;
    end
endmodule

// File: rtl/hwsat_lane.sv
module hwsat_lane
    import hwsat_pkg::*;
(
    input  logic [HW_LANE_W-1:0] din,
    input  sat_bounds_t          bnd,
    output lane_res_t            res
);
    logic signed [HW_BND_W-1:0] ext;
    logic                       above;
    logic                       below;

    always_comb begin
        ext   = $signed({din[HW_LANE_W-1], din});
        above = ext > bnd.hi;
        below = ext < bnd.lo;
        res.clip = above | below;
        if (above)
            res.val = bnd.hi[HW_LANE_W-1:0];
        else if (below)
            res.val = bnd.lo[HW_LANE_W-1:0];
        else
            res.val = din;
    end
endmodule

// File: rtl/hwsat_sticky.sv
module hwsat_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (clr)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
    end
endmodule

// File: rtl/hw_pair_clamp.sv
module hw_pair_clamp
    import hwsat_pkg::*;
#(
    parameter int LANES = 2,
    localparam int LANE_W = HW_LANE_W,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic                in_mode,
    input  logic [HW_SEL_W-1:0] in_sel,
    input  logic [WORD_W-1:0]   in_word,
    input  logic                flag_clr,
    output logic                out_vld,
    output logic [WORD_W-1:0]   out_word,
    output logic                sat_flag
);
    sat_bounds_t            bnd;
    sat_mode_e              mode_q;
    logic [WORD_W-1:0]      packed_res;
    logic [LANES-1:0]       clip_vec;
    logic                   any_clip;

    assign mode_q = sat_mode_e'(in_mode);

    hwsat_bounds u_bnd (
        .mode (mode_q),
        .sel  (in_sel),
        .bnd  (bnd)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_res_t r;
        hwsat_lane u_lane (
            .din (in_word[k*LANE_W +: LANE_W]),
            .bnd (bnd),
            .res (r)
        );
        assign packed_res[k*LANE_W +: LANE_W] = r.val;
        assign clip_vec[k]                    = r.clip;
    end

    assign any_clip = in_vld & (|clip_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_word <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld)
                out_word <= packed_res;
        end
    end

    hwsat_sticky u_flag (
        .clk (clk),
        .rst (rst),
        .set (any_clip),
        .clr (flag_clr),
        .q   (sat_flag)
    );
endmodule

// File: rtl/hwsat_chk.sv
module hwsat_chk #(
    parameter int LANES = 2,
    parameter int LANE_W = 16,
    parameter int SEL_W = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_vld,
    input logic                    in_mode,
    input logic [SEL_W-1:0]        in_sel,
    input logic [LANES*LANE_W-1:0] in_word,
    input logic                    flag_clr,
    input logic                    out_vld,
    input logic [LANES*LANE_W-1:0] out_word,
    input logic                    sat_flag
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!out_vld && !sat_flag && out_word == '0));

    a_r2_vld_follows: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && $stable(out_word)));

    for (genvar k = 0; k < LANES; k++) begin : g_uns
        a_r4_uns_nonneg: assert property (@(posedge clk) disable iff (rst)
            (in_vld && in_mode) |=> !out_word[k*LANE_W + LANE_W - 1]);
    end

    a_r7_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !flag_clr) |=> sat_flag);

    a_r7_flag_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_flag) |-> $past(in_vld));

    a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> !sat_flag);

    a_r9_full_pass: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_mode && in_sel == '1) |=> (out_word == $past(in_word)));
endmodule

bind hw_pair_clamp hwsat_chk #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .SEL_W  (hwsat_pkg::HW_SEL_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_mode  (in_mode),
    .in_sel   (in_sel),
    .in_word  (in_word),
    .flag_clr (flag_clr),
    .out_vld  (out_vld),
    .out_word (out_word),
    .sat_flag (sat_flag)
);

// File: tb/sim_hw_pair_clamp.sv
`timescale 1ns/1ps
module sim_hw_pair_clamp;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic        in_mode = 1'b0;
    logic [3:0]  in_sel = '0;
    logic [31:0] in_word = '0;
    logic        flag_clr = 1'b0;
    logic        out_vld;
    logic [31:0] out_word;
    logic        sat_flag;

    int n_checks = 0;
    int n_fail = 0;
    logic exp_flag = 1'b0;
    logic [31:0] exp_word = '0;

    always #5 clk = ~clk;

    hw_pair_clamp u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_mode(in_mode),
        .in_sel(in_sel), .in_word(in_word), .flag_clr(flag_clr),
        .out_vld(out_vld), .out_word(out_word), .sat_flag(sat_flag)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] ref_lane(input logic m, input logic [3:0] s,
                                             input logic [15:0] x, output logic clip);
        int v, hi, lo;
        v  = int'($signed(x));
        hi = (1 << s) - 1;
        lo = m ? 0 : -(1 << s);
        clip = 1'b0;
        if (v > hi) begin v = hi; clip = 1'b1; end
        else if (v < lo) begin v = lo; clip = 1'b1; end
        return v[15:0];
    endfunction

    task automatic do_op(input string req, input logic m, input logic [3:0] s,
                         input logic [31:0] w, input logic clr);
        logic c0, c1;
        logic [15:0] l0, l1;
        l0 = ref_lane(m, s, w[15:0], c0);
        l1 = ref_lane(m, s, w[31:16], c1);
        exp_word = {l1, l0};
        if (clr) exp_flag = 1'b0;
        else if (c0 | c1) exp_flag = 1'b1;
        @(negedge clk);
        in_vld = 1'b1; in_mode = m; in_sel = s; in_word = w; flag_clr = clr;
        @(negedge clk);
        in_vld = 1'b0; flag_clr = 1'b0;
        chk({req, " word"}, out_word, exp_word);
        chk({req, " vld"}, {31'b0, out_vld}, 32'd1);
        chk({req, " flag"}, {31'b0, sat_flag}, {31'b0, exp_flag});
    endtask

    task automatic clear_flag(input string req);
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        exp_flag = 1'b0;
        chk({req, " cleared"}, {31'b0, sat_flag}, 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 word", out_word, 32'd0);
        chk("R1 vld", {31'b0, out_vld}, 32'd0);
        chk("R1 flag", {31'b0, sat_flag}, 32'd0);
    endtask

    task automatic t_signed;
        do_op("R3 R5 s7", 1'b0, 4'd7, 32'h0100_FF00, 1'b0);
        chk("R3 R5 packed", out_word, 32'h007F_FF80);
        clear_flag("R8");
        do_op("R3 s0", 1'b0, 4'd0, 32'h0002_FFFE, 1'b0);
        chk("R3 s0 exact", out_word, 32'h0000_FFFF);
        clear_flag("R8");
        do_op("R3 edge", 1'b0, 4'd4, 32'h000F_FFF0, 1'b0);
        chk("R3 edge flag", {31'b0, sat_flag}, 32'd0);
    endtask

    task automatic t_unsigned;
        do_op("R4 s8", 1'b1, 4'd8, 32'h0123_FFF0, 1'b0);
        chk("R4 packed", out_word, 32'h00FF_0000);
        clear_flag("R8");
        do_op("R4 s0", 1'b1, 4'd0, 32'h0001_0000, 1'b0);
        chk("R4 s0 flag", {31'b0, sat_flag}, 32'd1);
        clear_flag("R8");
    endtask

    task automatic t_pass;
        do_op("R9 full", 1'b0, 4'd15, 32'h8000_7FFF, 1'b0);
        chk("R9 unchanged", out_word, 32'h8000_7FFF);
        chk("R9 no flag", {31'b0, sat_flag}, 32'd0);
    endtask

    task automatic t_indep;
        do_op("R6 hi clip", 1'b0, 4'd3, 32'h0009_0005, 1'b0);
        chk("R6 lo kept", {16'b0, out_word[15:0]}, 32'h0000_0005);
        do_op("R6 lo clip", 1'b0, 4'd3, 32'hFFFC_8000, 1'b0);
        chk("R6 hi kept", {16'b0, out_word[31:16]}, 32'h0000_FFFC);
    endtask

    task automatic t_sticky;
        do_op("R7 set", 1'b1, 4'd2, 32'h0000_0010, 1'b0);
        do_op("R7 keep", 1'b0, 4'd15, 32'h0001_0001, 1'b0);
        chk("R7 still set", {31'b0, sat_flag}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R7 idle keep", {31'b0, sat_flag}, 32'd1);
    endtask

    task automatic t_clr_prio;
        do_op("R8 prio", 1'b0, 4'd1, 32'h0040_0000, 1'b1);
        chk("R8 prio flag", {31'b0, sat_flag}, 32'd0);
        chk("R8 result written", out_word, 32'h0001_0000);
    endtask

    task automatic t_hold;
        logic [31:0] held;
        do_op("R2 load", 1'b0, 4'd15, 32'h1234_5678, 1'b0);
        held = out_word;
        @(negedge clk);
        in_word = 32'hDEAD_BEEF; in_sel = 4'd0;
        repeat (3) @(negedge clk);
        chk("R2 vld low", {31'b0, out_vld}, 32'd0);
        chk("R2 hold", out_word, held);
    endtask

    task automatic t_sweep;
        logic [15:0] vals [8];
        vals = '{16'h8000, 16'hFF38, 16'hFFFF, 16'h0000,
                 16'h0001, 16'h0064, 16'h012C, 16'h7FFF};
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 16; s++)
                for (int i = 0; i < 8; i++) begin
                    do_op(m ? "R4 sweep" : "R3 sweep", m[0], s[3:0],
                          {vals[(i + 3) % 8], vals[i]}, 1'b0);
                    clear_flag("R8 sweep");
                end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_signed();
        t_unsigned();
        t_pass();
        t_indep();
        t_sticky();
        t_clr_prio();
        t_hold();
        t_sweep();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule